// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block runs the timed internal phase of a byte-wide flash memory's write operations. A command decoder sends it a one-clock start pulse for one of three operations: byte program, page erase or chip erase. With the pulse come a target address and, for a program, a data byte. The block holds a busy flag for a parameterised number of clock cycles, which stands in for the physical program or erase time. At the end of that time it writes the result into a small internal byte array and raises a one-clock completion pulse.

The host reads through the same block at all times. While an operation is running, a read does not return array contents. It returns a status byte instead. Bit 7 is the polling bit, and its value depends on the kind of operation. Bit 6 flips on every read. Bits 5..0 are zero. After the operation ends, reads return array data again with no command needed.

Top module: `eop_status_reporter`

## Requirements
- R1: A byte program leaves the target location holding the old stored byte ANDed bitwise with the programmed byte, so programming can only clear bits.
- R2: During a program, status bit 7 reads as the inverse of bit 7 of the byte being programmed. During either erase it reads 0.
- R3: While busy, status bit 6 reads 0 on the first read after the start and flips on each later read, whatever the read address. Status bits 5..0 read 0.
- R4: `busy` rises on the clock after an accepted start and stays high for exactly PROG_CYCLES cycles for a program, or ERASE_CYCLES cycles for either erase.
- R5: `done` is high for exactly one cycle: the cycle right after `busy` falls. It is never high together with `busy`.
- R6: A chip erase sets every array byte to FFh.
- R7: A page erase sets to FFh only the bytes whose top PAGE_BITS address bits (op_addr[ADDR_W-1 -: PAGE_BITS]) equal those of `op_addr`. All other bytes are unchanged.
- R8: The first read issued once `busy` is low returns the array byte with the completed operation's result already applied.
- R9: A start pulse that arrives while `busy` is high is ignored. It does not change the running operation, its duration or the array.
- R10: When start pulses arrive together, chip erase wins over page erase, and page erase wins over program. Only the winner runs.
- R11: After reset, `busy`, `done` and `rd_data` are 0, and every array byte is FFh.
- R12: `rd_data` updates on the clock edge where `rd_en` is sampled high, and holds its value in cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | One-cycle request to program a byte |
| page_erase_start | input | 1 | One-cycle request to erase the page holding `op_addr` |
| chip_erase_start | input | 1 | One-cycle request to erase the whole array |
| op_addr | input | ADDR_W | Target address for a program; any address inside the page for a page erase |
| op_data | input | 8 | Byte to program |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result: array byte or status byte |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
Embedded assertions check these properties on every cycle: completion and busy never overlap, completion lasts one cycle, busy always falls into a completion pulse, busy reads have zero low bits and a zero polling bit during erase, and a program applies the AND rule to the addressed byte. Other behaviour can only be shown by the bench's scenarios. This covers the exact busy length for each operation type, the alternating toggle sequence across reads, which array locations a page erase touches, the handling of start pulses while busy or arriving together, and the array contents seen by the first read after completion.

// File: rtl/eop_pkg.sv
package eop_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_PAGE = 2'd2,
        OP_CHIP = 2'd3
    } op_e;
endpackage

// File: rtl/eop_sequencer.sv
module eop_sequencer
    import eop_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int PROG_CYCLES  = 5,
    parameter int ERASE_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic              page_start,
    input  logic              chip_start,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    output logic              busy,
    output logic              done,
    output logic              accept,
    output logic              apply,
    output op_e               op,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        tgt_data
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        op_e               op;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = 1'b0;
        apply    = 1'b0;
        if (!s_q.busy) begin
            // fixed priority: chip erase, then page erase, then program
            if (chip_start || page_start || prog_start) begin
                accept   = 1'b1;
                s_d.busy = 1'b1;
                s_d.addr = op_addr;
                s_d.data = op_data;
                if (chip_start) begin
                    s_d.op  = OP_CHIP;
                    s_d.cnt = CNT_W'(ERASE_CYCLES - 1);
                end else if (page_start) begin
                    s_d.op  = OP_PAGE;
                    s_d.cnt = CNT_W'(ERASE_CYCLES - 1);
                end else begin
                    s_d.op  = OP_PROG;
                    s_d.cnt = CNT_W'(PROG_CYCLES - 1);
                end
            end
        end else if (s_q.cnt == '0) begin
            apply    = 1'b1;
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.op   = OP_NONE;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign op       = s_q.op;
    assign tgt_addr = s_q.addr;
    assign tgt_data = s_q.data;

    // R5
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !s_q.busy);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    // R5
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> s_q.done);
    // R9
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> $stable(s_q.op) && $stable(s_q.addr));
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CNT_W'(MAX_CYC));
endmodule

// File: rtl/eop_array.sv
module eop_array
    import eop_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  op_e               op,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int OFFS  = ADDR_W - PAGE_BITS;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic [7:0] old_byte;

    assign old_byte = mem_q[wr_addr];
    assign rd_byte  = mem_q[rd_addr];

    always_comb begin
        mem_d = mem_q;
        if (apply) begin
            unique case (op)
                OP_PROG: mem_d[wr_addr] = old_byte & wr_data;
                OP_PAGE: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if ((ADDR_W'(i) >> OFFS) == (wr_addr >> OFFS)) mem_d[i] = 8'hFF;
                    end
                end
                OP_CHIP: begin
                    for (int i = 0; i < DEPTH; i++) mem_d[i] = 8'hFF;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            mem_q <= mem_d;
        end
    end

    // R1
    prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && op == OP_PROG) |=> mem_q[$past(wr_addr)] == $past(old_byte & wr_data));
endmodule

// File: rtl/eop_status_reporter.sv
module eop_status_reporter
    import eop_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int PAGE_BITS    = 2,
    parameter int PROG_CYCLES  = 5,
    parameter int ERASE_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic              page_erase_start,
    input  logic              chip_erase_start,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        logic [7:0] rdat;
        logic       tgl;
    } rd_t;

    rd_t              r_d, r_q;
    logic             accept, apply;
    op_e              op;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]       tgt_data;
    logic [7:0]       arr_byte;
    logic             poll_bit;

    eop_sequencer #(
        .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .prog_start(prog_start), .page_start(page_erase_start), .chip_start(chip_erase_start),
        .op_addr(op_addr), .op_data(op_data),
        .busy(busy), .done(done), .accept(accept), .apply(apply),
        .op(op), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    eop_array #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
    ) u_arr (
        .clk(clk), .rst_n(rst_n),
        .apply(apply), .op(op), .wr_addr(tgt_addr), .wr_data(tgt_data),
        .rd_addr(rd_addr), .rd_byte(arr_byte)
    );

    // polling bit: inverted programmed bit 7 during a program, low during erase
    assign poll_bit = (op == OP_PROG) ? ~tgt_data[7] : 1'b0;

    always_comb begin
        r_d = r_q;
        if (accept) r_d.tgl = 1'b0;
        if (rd_en) begin
            if (busy) begin
                r_d.rdat = {poll_bit, r_q.tgl, 6'b0};
                r_d.tgl  = ~r_q.tgl;
            end else begin
                r_d.rdat = arr_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.rdat;

    // R3
    busy_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> rd_data[5:0] == 6'b0);
    // R2
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en && op != OP_PROG) |=> !rd_data[7]);
    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/eop_status_reporter_tb.sv
module eop_status_reporter_tb;
    localparam int AW = 8;
    localparam int PC = 5;
    localparam int EC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_start = 1'b0, page_erase_start = 1'b0, chip_erase_start = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [7:0]    op_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy, done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eop_status_reporter #(
        .ADDR_W(AW), .PAGE_BITS(2), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .prog_start(prog_start), .page_erase_start(page_erase_start),
        .chip_erase_start(chip_erase_start),
        .op_addr(op_addr), .op_data(op_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    // vector: {op[1:0], addr, data, check address, expected byte}; op 0 read, 1 program, 2 page erase, 3 chip erase
    localparam int NV = 10;
    localparam logic [33:0] VEC [NV] = '{
        {2'd1, 8'h10, 8'hA5, 8'h10, 8'hA5},
        {2'd1, 8'h10, 8'h3C, 8'h10, 8'h24},
        {2'd1, 8'h80, 8'h7F, 8'h80, 8'h7F},
        {2'd1, 8'h3F, 8'h11, 8'h3F, 8'h11},
        {2'd1, 8'h40, 8'h22, 8'h40, 8'h22},
        {2'd2, 8'h20, 8'h00, 8'h3F, 8'hFF},
        {2'd0, 8'h00, 8'h00, 8'h40, 8'h22},
        {2'd0, 8'h00, 8'h00, 8'h10, 8'hFF},
        {2'd1, 8'hC1, 8'h00, 8'h80, 8'h7F},
        {2'd3, 8'h00, 8'h00, 8'hC1, 8'hFF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    // start one operation and poll until it completes; extra is an ignored start during busy
    task automatic run_op(input logic [1:0] kind, input logic [AW-1:0] a, input logic [7:0] d,
                          input bit extra);
        int n;
        bit tg;
        bit exp7;
        int len;
        logic [7:0] v;
        len  = (kind == 2'd1) ? PC : EC;
        exp7 = (kind == 2'd1) ? ~d[7] : 1'b0;
        op_addr = a; op_data = d;
        prog_start = (kind == 2'd1);
        page_erase_start = (kind == 2'd2);
        chip_erase_start = (kind == 2'd3);
        @(negedge clk);
        prog_start = 1'b0; page_erase_start = 1'b0; chip_erase_start = 1'b0;
        chk(busy === 1'b1, "R4 busy after start", busy, 1);
        n = 0; tg = 1'b0;
        while (busy === 1'b1 && n < 100) begin
            if (extra && n == 1) begin
                prog_start = 1'b1; op_addr = 8'h55; op_data = 8'h00;
            end
            rd(AW'(n * 37), v);
            prog_start = 1'b0;
            chk(v[7] === exp7, "R2 polling bit", v[7], exp7);
            chk(v[6] === tg, "R3 toggle bit", v[6], tg);
            chk(v[5:0] === 6'b0, "R3 low status bits", v[5:0], 0);
            tg = ~tg;
            n++;
        end
        chk(n == len, "R4 busy length", n, len);
        chk(done === 1'b1, "R5 done after busy", done, 1);
        @(negedge clk);
        chk(done === 1'b0, "R5 done one cycle", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy === 1'b0, "R11 busy reset", busy, 0);
        chk(done === 1'b0, "R11 done reset", done, 0);
        chk(rd_data === 8'h00, "R11 rd_data reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'hE7, v);
        chk(v === 8'hFF, "R11 array erased at reset", v, 8'hFF);
        // R12 hold without rd_en
        @(negedge clk);
        chk(rd_data === 8'hFF, "R12 hold", rd_data, 8'hFF);

        // R1 R6 R7 R8 vector table
        for (int i = 0; i < NV; i++) begin
            logic [33:0] e;
            e = VEC[i];
            if (e[33:32] != 2'd0) run_op(e[33:32], e[31:24], e[23:16], 1'b0);
            // first read after completion returns array data (R8)
            rd(e[15:8], v);
            chk(v === e[7:0], "R1/R6/R7/R8 array data", v, e[7:0]);
        end
        rd(8'h80, v);
        chk(v === 8'hFF, "R6 chip erase other byte", v, 8'hFF);

        // R9 start during busy ignored
        run_op(2'd2, 8'hC0, 8'h00, 1'b1);
        rd(8'h55, v);
        chk(v === 8'hFF, "R9 ignored program", v, 8'hFF);

        // R10 simultaneous starts: chip erase wins over program
        run_op(2'd1, 8'h07, 8'h0F, 1'b0);
        op_addr = 8'h90; op_data = 8'h00;
        prog_start = 1'b1; chip_erase_start = 1'b1; page_erase_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0; chip_erase_start = 1'b0; page_erase_start = 1'b0;
        begin
            int n;
            n = 0;
            while (busy === 1'b1 && n < 100) begin
                rd(8'h90, v);
                chk(v[7] === 1'b0, "R10 erase polling wins", v[7], 0);
                n++;
            end
            chk(n == EC, "R10 erase duration", n, EC);
        end
        rd(8'h90, v);
        chk(v === 8'hFF, "R10 program not run", v, 8'hFF);
        rd(8'h07, v);
        chk(v === 8'hFF, "R10 chip erase ran", v, 8'hFF);

        // R10 page erase wins over program
        run_op(2'd1, 8'hC5, 8'h00, 1'b0);
        op_addr = 8'h05; op_data = 8'h00;
        prog_start = 1'b1; page_erase_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0; page_erase_start = 1'b0;
        while (busy === 1'b1) @(negedge clk);
        rd(8'h05, v);
        chk(v === 8'hFF, "R10 page over program", v, 8'hFF);
        rd(8'hC5, v);
        chk(v === 8'h00, "R7 other page kept", v, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule